// File: doc/BRIEF.md
# Fast-page DRAM burst write sequencer

This block turns a burst write request from an internal bus master into the strobe and address sequence that an EDO-style DRAM needs on a 16-bit data bus. The requester supplies a byte start address, a beat count and a pair of byte enables. The sequencer then opens one row, writes up to `MAX_BEATS` consecutive words inside that row, closes the row and reports completion. Write data is pulled from the requester one word per beat through a take pulse.

Each access starts with a three-cycle row phase. The row address is on the multiplexed address bus for all three cycles, and the row strobe goes low at the start of the second cycle. After that, each data beat gets a column cycle that is two clocks long. At the rising edge that opens a column cycle, the column address and the write data are driven and the write strobe is already low. The column strobe of each enabled byte lane falls at the falling edge inside the first clock and rises at the falling edge inside the second clock. This half-cycle offset comes from a small output stage clocked on the falling edge. There are two column strobes, one per byte lane, and one write strobe shared by both lanes.

Top module: `hpdram_wr_seq`

## Requirements
- R1: During and after reset, with no request: `ras_n_o`, `cas_lo_n_o`, `cas_hi_n_o` and `we_n_o` are high, `ma_o` is zero, and `dq_oe_o`, `take_o` and `done_o` are low.
- R2: `req_i` is acted on only at a rising edge where the sequencer is idle. A request raised while a burst is running starts no access: no row strobe falls after that burst ends.
- R3: The row phase lasts three cycles. During it, `ma_o` carries the row, which is `addr_i[ADDR_W-1:COL_W+1]`. `ras_n_o` is high in the first row cycle, falls at the start of the second, and stays low through the last column cycle.
- R4: The burst has `len_i`+1 beats. Each beat is a column cycle of two clocks. During beat k, `ma_o` carries (`addr_i[COL_W:1]` + k) modulo 2^COL_W, so the burst stays in the same row. `dq_o` carries that beat's data and `dq_oe_o` is high.
- R5: In each column cycle, an enabled lane's column strobe falls at the falling clock edge inside the first clock. It rises at the falling edge inside the second clock.
- R6: `we_n_o` is low from the rising edge that opens the first column cycle until the rising edge that ends the last one, and high at all other times. Every column strobe falls while `we_n_o` and `ras_n_o` are low. `ma_o` and `dq_o` do not change while any column strobe is low.
- R7: `be_i[0]` enables `cas_lo_n_o`, which strobes `dq_o[7:0]`. `be_i[1]` enables `cas_hi_n_o`, which strobes `dq_o[15:8]`. A disabled lane never strobes during that burst, while `we_n_o` still goes low.
- R8: `done_o` is high for exactly one cycle: the cycle that begins 3+2n rising edges after the accepting edge, where n is the beat count. In that cycle `ras_n_o` and `we_n_o` are high.
- R9: `take_o` is high in the third row cycle and in the second clock of every column cycle except the last. `wdata_i` is captured at the rising edge that ends each such cycle.
- R10: Between two bursts, `ras_n_o` stays high for at least one full clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst write request |
| addr_i | input | ADDR_W | Byte start address (bit 0 ignored) |
| len_i | input | LEN_W | Beat count minus one |
| be_i | input | 2 | Byte lane enables for the whole burst |
| wdata_i | input | 16 | Write data for the next beat |
| take_o | output | 1 | wdata_i is captured at the end of this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_lo_n_o | output | 1 | Low-byte column strobe, active low |
| cas_hi_n_o | output | 1 | High-byte column strobe, active low |
| we_n_o | output | 1 | Shared write strobe, active low |
| ma_o | output | MA_W | Multiplexed row/column address |
| dq_o | output | 16 | Write data bus |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
A wrong state in the sequencer shows up at the ports within one cycle. The row strobe falls early, a row cycle is missing, or the done pulse moves away from cycle 3+2n. A wrong beat count shows up as an extra or missing column strobe, and as a wrong take count, by the end of the burst. Column-address or data-capture errors appear as the wrong word latched at a column strobe falling edge, half a cycle after the column cycle opens. A lost byte enable or a stray retriggered request shows up either as a strobe count that does not match or as a row strobe with no request behind it, within a few cycles of done.

// File: rtl/hpdram_wr_pkg.sv
package hpdram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW1, ST_ROW2, ST_ROW3, ST_COLA, ST_COLB
  } seq_st_e;

  function automatic logic row_open(seq_st_e s);
    return (s == ST_ROW2) || (s == ST_ROW3) || (s == ST_COLA) || (s == ST_COLB);
  endfunction

  function automatic logic in_col(seq_st_e s);
    return (s == ST_COLA) || (s == ST_COLB);
  endfunction

  function automatic logic in_row(seq_st_e s);
    return (s == ST_ROW1) || (s == ST_ROW2) || (s == ST_ROW3);
  endfunction
endpackage

// File: rtl/hpdram_wr_fsm.sv
module hpdram_wr_fsm
  import hpdram_wr_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output seq_st_e          st_o,
  output seq_st_e          st_nxt_o,
  output logic             accept_o,
  output logic             take_o,
  output logic             col_adv_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] LenMax = LEN_W'(MAX_BEATS - 1);

  seq_st_e          st_q, st_d;
  logic [LEN_W-1:0] left_q;
  logic             last, accept;
  logic             done_q;

  assign last   = (left_q == '0);
  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_ROW1;
      ST_ROW1: st_d = ST_ROW2;
      ST_ROW2: st_d = ST_ROW3;
      ST_ROW3: st_d = ST_COLA;
      ST_COLA: st_d = ST_COLB;
      ST_COLB: st_d = last ? ST_IDLE : ST_COLA;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_COLB) && last;
      if (accept)
        left_q <= (len_i > LenMax) ? LenMax : len_i;
      else if ((st_q == ST_COLB) && !last)
        left_q <= left_q - 1'b1;
    end
  end

  assign st_o      = st_q;
  assign st_nxt_o  = st_d;
  assign accept_o  = accept;
  // capture edge for the next beat's data
  assign take_o    = (st_q == ST_ROW3) || ((st_q == ST_COLB) && !last);
  assign col_adv_o = (st_q == ST_COLB);
  assign done_o    = done_q;
endmodule

// File: rtl/hpdram_wr_addr.sv
module hpdram_wr_addr
  import hpdram_wr_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int MA_W   = 10,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           st_i,
  input  logic              accept_i,
  input  logic              take_i,
  input  logic              col_adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MA_W-1:0]   ma_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      dat_q <= '0;
    end else begin
      if (accept_i) begin
        row_q <= addr_i[ADDR_W-1 -: ROW_W];
        col_q <= addr_i[COL_W:1];
      end else if (col_adv_i) begin
        col_q <= col_q + 1'b1;  // wraps inside the open row
      end
      if (take_i) dat_q <= wdata_i;
    end
  end

  always_comb begin
    ma_o = '0;
    if (in_row(st_i))      ma_o = MA_W'(row_q);
    else if (in_col(st_i)) ma_o = MA_W'(col_q);
  end

  assign dq_oe_o = in_col(st_i);
  assign dq_o    = dq_oe_o ? dat_q : '0;
endmodule

// File: rtl/hpdram_wr_strobe.sv
module hpdram_wr_strobe
  import hpdram_wr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          st_i,
  input  seq_st_e          st_nxt_i,
  input  logic             accept_i,
  input  logic [LANES-1:0] be_i,
  output logic             ras_n_o,
  output logic             we_n_o,
  output logic [LANES-1:0] cas_n_o
);
  logic [LANES-1:0] be_q;
  logic             ras_n_q, we_n_q;

  // registered from next state: glitch-free strobes aligned to the state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q    <= '0;
      ras_n_q <= 1'b1;
      we_n_q  <= 1'b1;
    end else begin
      if (accept_i) be_q <= be_i;
      ras_n_q <= !row_open(st_nxt_i);
      we_n_q  <= !in_col(st_nxt_i);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic cas_q;
    // falling-edge stage: low mid first clock, high mid second clock
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cas_q <= 1'b1;
      else         cas_q <= !((st_i == ST_COLA) && be_q[g]);
    end
    assign cas_n_o[g] = cas_q;
  end

  assign ras_n_o = ras_n_q;
  assign we_n_o  = we_n_q;
endmodule

// File: rtl/hpdram_wr_seq.sv
module hpdram_wr_seq
  import hpdram_wr_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int MAX_BEATS = 4,
  localparam int ADDR_W   = ROW_W + COL_W + 1,
  localparam int LEN_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  output logic              take_o,
  output logic              done_o,
  output logic              ras_n_o,
  output logic              cas_lo_n_o,
  output logic              cas_hi_n_o,
  output logic              we_n_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [15:0]       dq_o,
  output logic              dq_oe_o
);
  localparam int DataW = 16;
  localparam int Lanes = DataW / 8;

  seq_st_e          st, st_nxt;
  logic             accept, col_adv;
  logic [Lanes-1:0] cas_n;

  hpdram_wr_fsm #(.MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W)) i_fsm (
    .clk_i, .rst_ni, .req_i, .len_i,
    .st_o(st), .st_nxt_o(st_nxt), .accept_o(accept),
    .take_o, .col_adv_o(col_adv), .done_o
  );

  hpdram_wr_addr #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W), .ADDR_W(ADDR_W), .DATA_W(DataW)
  ) i_addr (
    .clk_i, .rst_ni, .st_i(st), .accept_i(accept), .take_i(take_o),
    .col_adv_i(col_adv), .addr_i, .wdata_i, .ma_o, .dq_o, .dq_oe_o
  );

  hpdram_wr_strobe #(.LANES(Lanes)) i_strobe (
    .clk_i, .rst_ni, .st_i(st), .st_nxt_i(st_nxt), .accept_i(accept),
    .be_i, .ras_n_o, .we_n_o, .cas_n_o(cas_n)
  );

  assign cas_lo_n_o = cas_n[0];
  assign cas_hi_n_o = cas_n[1];
endmodule

// File: rtl/hpdram_wr_chk.sv
module hpdram_wr_chk #(
  parameter int MA_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ras_n_o,
  input logic            cas_lo_n_o,
  input logic            cas_hi_n_o,
  input logic            we_n_o,
  input logic [MA_W-1:0] ma_o,
  input logic [15:0]     dq_o,
  input logic            dq_oe_o,
  input logic            take_o,
  input logic            done_o
);
  AST_CAS_UNDER_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_lo_n_o || !cas_hi_n_o) |-> (!we_n_o && !ras_n_o)); // R6

  AST_HOLD_ACROSS_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_lo_n_o || !cas_hi_n_o) |=> ($stable(ma_o) && $stable(dq_o))); // R6

  AST_CAS_CLOSED_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_o |-> (cas_lo_n_o && cas_hi_n_o)); // R5

  AST_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |=> $stable(ma_o)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_WE_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> done_o); // R8

  AST_OE_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> dq_oe_o); // R4

  AST_TAKE_ROW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ras_n_o); // R9
endmodule

bind hpdram_wr_seq hpdram_wr_chk #(.MA_W(MA_W)) i_hpdram_wr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_o(ras_n_o), .cas_lo_n_o(cas_lo_n_o),
  .cas_hi_n_o(cas_hi_n_o), .we_n_o(we_n_o), .ma_o(ma_o), .dq_o(dq_o),
  .dq_oe_o(dq_oe_o), .take_o(take_o), .done_o(done_o)
);

// File: tb/test_hpdram_wr_seq.sv
`timescale 1ns/1ps
module test_hpdram_wr_seq;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 8;
  localparam int ADDR_W = ROW_W + COL_W + 1;
  localparam int LEN_W  = 2;
  localparam int MA_W   = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [1:0]        be = '0;
  logic [15:0]       wdata;
  logic              take, done, ras_n, cas_lo_n, cas_hi_n, we_n, dq_oe;
  logic [MA_W-1:0]   ma;
  logic [15:0]       dq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hpdram_wr_seq i_hpdram_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .be_i(be), .wdata_i(wdata), .take_o(take), .done_o(done),
    .ras_n_o(ras_n), .cas_lo_n_o(cas_lo_n), .cas_hi_n_o(cas_hi_n),
    .we_n_o(we_n), .ma_o(ma), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [15:0] data_fn(int c);
    return 16'(c * 40503) ^ 16'hA55A;
  endfunction

  // requester data source
  int take_cnt = 0;
  always @(posedge clk) if (take) take_cnt <= take_cnt + 1;
  assign wdata = data_fn(take_cnt);

  // behavioural DRAM-side monitor
  int n_lo = 0, n_hi = 0, ras_falls = 0, we_bad = 0, stab_bad = 0, prech_bad = 0;
  logic [MA_W-1:0] lo_col[64], hi_col[64];
  logic [7:0]      lo_dat[64], hi_dat[64];
  logic [MA_W-1:0] lo_ma, hi_ma, ras_row;
  logic [7:0]      lo_dq, hi_dq;
  realtime         ras_rise_t = 0.0;

  always @(negedge cas_lo_n) if (rst_n) begin
    lo_col[n_lo % 64] = ma; lo_dat[n_lo % 64] = dq[7:0];
    lo_ma = ma; lo_dq = dq[7:0];
    if (we_n || ras_n) we_bad++;
    n_lo++;
  end
  always @(posedge cas_lo_n) if (rst_n && n_lo > 0)
    if (ma != lo_ma || dq[7:0] != lo_dq) stab_bad++;
  always @(negedge cas_hi_n) if (rst_n) begin
    hi_col[n_hi % 64] = ma; hi_dat[n_hi % 64] = dq[15:8];
    hi_ma = ma; hi_dq = dq[15:8];
    if (we_n || ras_n) we_bad++;
    n_hi++;
  end
  always @(posedge cas_hi_n) if (rst_n && n_hi > 0)
    if (ma != hi_ma || dq[15:8] != hi_dq) stab_bad++;
  always @(negedge ras_n) if (rst_n) begin
    ras_row = ma;
    if ($realtime - ras_rise_t < 5.0) prech_bad++;
    ras_falls++;
  end
  always @(posedge ras_n) ras_rise_t = $realtime;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", r, act, exp, $time);
    end
  endtask

  task automatic run_burst(input logic [ADDR_W-1:0] a, input int n,
                           input logic [1:0] b, input bit poke);
    logic [MA_W-1:0] row, col0, colx;
    int lo0, hi0, rf0, tk0, wb0, sb0, k, beat, tk_seen;
    bit cola, en_lo, en_hi;
    row  = MA_W'(a[ADDR_W-1 -: ROW_W]);
    col0 = MA_W'(a[COL_W:1]);
    lo0 = n_lo; hi0 = n_hi; rf0 = ras_falls; tk0 = take_cnt;
    wb0 = we_bad; sb0 = stab_bad; tk_seen = 0;
    en_lo = b[0]; en_hi = b[1];
    req = 1'b1; addr = a; len = LEN_W'(n - 1); be = b;
    @(posedge clk); #1;
    req = 1'b0; addr = ADDR_W'($urandom); len = LEN_W'($urandom); be = 2'($urandom);
    k = 0;
    while (k < 60) begin
      if (done) break;
      if (take) tk_seen++;
      if (k < 3) begin
        chk(ma == row, "R3 row address", ma, row);
        chk(ras_n == (k == 0), "R3 row strobe", ras_n, k == 0);
        chk(take == (k == 2), "R9 take in row phase", take, k == 2);
      end else begin
        beat = (k - 3) / 2;
        cola = ((k - 3) % 2) == 0;
        colx = MA_W'(COL_W'(col0 + beat));
        chk(ma == colx, "R4 column address", ma, colx);
        chk(dq == data_fn(tk0 + beat) && dq_oe, "R4 write data", dq, data_fn(tk0 + beat));
        chk(!we_n && !ras_n, "R6 WE/RAS low in column", {we_n, ras_n}, 0);
        chk(take == (!cola && beat < n - 1), "R9 take in column", take, !cola && beat < n - 1);
        chk({cas_hi_n, cas_lo_n} == (cola ? 2'b11 : ~b), "R5 CAS before falling edge",
            {cas_hi_n, cas_lo_n}, cola ? 2'b11 : ~b);
        #2.5;
        chk({cas_hi_n, cas_lo_n} == (cola ? ~b : 2'b11), "R5 CAS after falling edge",
            {cas_hi_n, cas_lo_n}, cola ? ~b : 2'b11);
        #(-0.0);
      end
      if (poke && k == 4) begin req = 1'b1; addr = ADDR_W'($urandom); end
      if (poke && k == 5) req = 1'b0;
      @(posedge clk); #1;
      k++;
    end
    req = 1'b0;
    chk(k == 3 + 2 * n, "R8 done latency", k, 3 + 2 * n);
    chk(ras_n && we_n, "R8 strobes high at done", {ras_n, we_n}, 3);
    chk(tk_seen == n, "R9 take count", tk_seen, n);
    @(posedge clk); #1;
    chk(!done, "R8 done single cycle", done, 0);
    chk(ras_falls - rf0 == 1 && ras_row == row, "R3 latched row", ras_row, row);
    chk(n_lo - lo0 == (en_lo ? n : 0), "R7 low lane strobes", n_lo - lo0, en_lo ? n : 0);
    chk(n_hi - hi0 == (en_hi ? n : 0), "R7 high lane strobes", n_hi - hi0, en_hi ? n : 0);
    for (int i = 0; i < n; i++) begin
      colx = MA_W'(COL_W'(col0 + i));
      if (en_lo) begin
        chk(lo_col[(lo0 + i) % 64] == colx, "R4 low lane column", lo_col[(lo0 + i) % 64], colx);
        chk(lo_dat[(lo0 + i) % 64] == data_fn(tk0 + i)[7:0], "R7 low byte",
            lo_dat[(lo0 + i) % 64], data_fn(tk0 + i)[7:0]);
      end
      if (en_hi) begin
        chk(hi_col[(hi0 + i) % 64] == colx, "R4 high lane column", hi_col[(hi0 + i) % 64], colx);
        chk(hi_dat[(hi0 + i) % 64] == data_fn(tk0 + i)[15:8], "R7 high byte",
            hi_dat[(hi0 + i) % 64], data_fn(tk0 + i)[15:8]);
      end
    end
    chk(we_bad == wb0, "R6 CAS fell without WE/RAS", we_bad - wb0, 0);
    chk(stab_bad == sb0, "R6 address/data moved under CAS", stab_bad - sb0, 0);
    if (poke) begin
      repeat (4) @(posedge clk);
      #1;
      chk(ras_falls == rf0 + 1 && ras_n, "R2 busy request ignored", ras_falls - rf0, 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #9;
    chk(ras_n && cas_lo_n && cas_hi_n && we_n, "R1 strobes in reset",
        {ras_n, cas_lo_n, cas_hi_n, we_n}, 4'hf);
    chk(ma == 0 && !dq_oe && !done && !take, "R1 outputs in reset", ma, 0);
    #2; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(ras_n && cas_lo_n && cas_hi_n && we_n && !done && ma == 0, "R1 idle after reset",
        {ras_n, cas_lo_n, cas_hi_n, we_n, done}, 5'h1e);

    // directed corners
    run_burst({10'h3a5, 8'hfe, 1'b0}, 4, 2'b11, 1'b0); // column wrap, full burst
    run_burst({10'h001, 8'h10, 1'b1}, 1, 2'b01, 1'b0); // single beat, low byte
    run_burst({10'h2ff, 8'h00, 1'b0}, 3, 2'b10, 1'b0); // high byte only
    run_burst({10'h155, 8'h7f, 1'b0}, 2, 2'b00, 1'b0); // no lane enabled
    run_burst({10'h0aa, 8'h40, 1'b0}, 4, 2'b11, 1'b1); // request while busy

    for (int it = 0; it < 40; it++) begin
      int n;
      n = 1 + int'($urandom % 4);
      run_burst(ADDR_W'($urandom), n, 2'($urandom), (n >= 2) && ($urandom % 4 == 0));
    end

    chk(prech_bad == 0, "R10 RAS precharge gap", prech_bad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule